// File: doc/BRIEF.md
# Interrupt Priority Acceptance Core

This block holds the pending and in-service state for a set of 256 interrupt vectors. It decides which pending vector, if any, may interrupt the core right now. Incoming vectors arrive on a request stream and set bits in a pending bit-map. Each accepted vector also records a trigger-mode flag. The block keeps a task priority byte and derives the processor priority from it and from the highest vector still in service.

The core sees an offer stream. The offer is valid when the highest pending vector's class (its upper nibble) is strictly above the processor priority. The core takes the offer by raising `offer_ready`. This moves the vector from pending to in-service, and the processor priority is recomputed from the new state.

An end-of-interrupt pulse retires the highest in-service vector. The retired vector and its trigger-mode flag are reported for one cycle. The task priority can be written as a full byte, or through a 4-bit class alias that reads and writes the upper nibble.

Stream rules: `req_ready` is held high, so a request is taken in every cycle in which `req_valid` is high. An offer completes on a cycle where `offer_valid` and `offer_ready` are both high. While no handshake completes, `offer_vector` stays stable unless a new request, an EOI or a priority write changes the decision. The core may hold `offer_ready` high in advance.

Top module: `irq_accept_core`

## Requirements
- R1: After reset the pending, in-service and trigger-mode maps and the task priority are all zero, so `offer_valid`=0, `proc_prio`=0, `tpr`=0 and `prio_class_rdata`=0.
- R2: `offer_valid` is 0 whenever `enable` is 0 or no pending bit is set. Pending state is still collected while `enable` is 0.
- R3: `offer_vector` is the highest-numbered pending vector. It is valid only when `{offer_vector[7:4],4'h0}` is strictly greater than `proc_prio`, so a vector whose class equals the processor priority class is held back.
- R4: On a cycle where `offer_valid` and `offer_ready` are both 1, the next clock edge clears that vector's pending bit and sets its in-service bit.
- R5: `proc_prio` equals `tpr` when the in-service map is empty or `tpr[7:4]` is at least the class of the highest in-service vector. Otherwise it equals that vector's class followed by four zero bits.
- R6: An `eoi` pulse clears the highest set in-service bit. In the next cycle `eoi_done_valid`=1 and `eoi_done_vector` holds that vector. When the in-service map is empty, `eoi` changes nothing and `eoi_done_valid` stays 0.
- R7: A write on `prio_class_wr` sets `tpr` to `{prio_class_wdata,4'h0}`. `prio_class_rdata` always shows `tpr[7:4]`.
- R8: A write on `tpr_wr` loads the full byte `tpr_wdata`. If both priority writes occur in the same cycle, the full-byte write wins.
- R9: A request for a vector that is already pending merges with it, so a single acknowledge and EOI leave nothing pending.
- R10: Requests for vectors 0 to 15 are discarded and never become pending.
- R11: Each accepted request stores `req_level` as the vector's trigger-mode flag. `eoi_done_level` reports the flag of the retired vector.
- R12: `req_ready` is always 1. A request for the vector being acknowledged in the same cycle stays pending after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; gates the offer |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready (always 1) |
| req_vector | input | 8 | Requested vector number |
| req_level | input | 1 | Trigger-mode flag of the request (1 = level) |
| offer_valid | output | 1 | A deliverable vector is offered |
| offer_ready | input | 1 | Core acknowledges the offered vector |
| offer_vector | output | 8 | Offered vector number |
| eoi | input | 1 | End-of-interrupt pulse |
| eoi_done_valid | output | 1 | A vector was retired in the previous cycle |
| eoi_done_vector | output | 8 | Retired vector number |
| eoi_done_level | output | 1 | Trigger-mode flag of the retired vector |
| tpr_wr | input | 1 | Full task priority write strobe |
| tpr_wdata | input | 8 | Full task priority write data |
| prio_class_wr | input | 1 | 4-bit class alias write strobe |
| prio_class_wdata | input | 4 | Class alias write data |
| prio_class_rdata | output | 4 | Class alias read value (`tpr[7:4]`) |
| tpr | output | 8 | Current task priority |
| proc_prio | output | 8 | Current processor priority |

## Verification
A stuck or wrong pending bit shows up in the cycle after the request. Either the wrong vector is offered, or a vector is offered when none should be. A corrupt in-service bit shows through `proc_prio` right after the acknowledge edge. It also shows one cycle after EOI, as the wrong retired vector or trigger flag. A bad priority comparison is exposed by sweeping every vector in turn and every task priority class against a fixed class-8 vector. Each sweep checks whether the offer appears on the exact cycle after the stimulus.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int NVEC  = 256;
  localparam int VW    = $clog2(NVEC);
  localparam int SUBW  = 4;
  localparam int CW    = VW - SUBW;
  localparam int MINV  = 16;

  typedef logic [VW-1:0] vec_t;
  typedef logic [CW-1:0] cls_t;

  function automatic vec_t class_of(vec_t v);
    return {v[VW-1:SUBW], {SUBW{1'b0}}};
  endfunction
endpackage

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_calc.sv
module irq_prio_calc
  import irq_accept_pkg::*;
(
  input  vec_t tpr_i,
  input  logic isr_any,
  input  vec_t isr_top,
  output vec_t ppr_o
);
  always_comb begin
    if (!isr_any || (tpr_i[VW-1:SUBW] >= isr_top[VW-1:SUBW]))
      ppr_o = tpr_i;
    else
      ppr_o = class_of(isr_top);
  end
endmodule

// File: rtl/irq_accept_core.sv
module irq_accept_core
  import irq_accept_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_vector,
  input  logic       req_level,
  output logic       offer_valid,
  input  logic       offer_ready,
  output logic [7:0] offer_vector,
  input  logic       eoi,
  output logic       eoi_done_valid,
  output logic [7:0] eoi_done_vector,
  output logic       eoi_done_level,
  input  logic       tpr_wr,
  input  logic [7:0] tpr_wdata,
  input  logic       prio_class_wr,
  input  logic [3:0] prio_class_wdata,
  output logic [3:0] prio_class_rdata,
  output logic [7:0] tpr,
  output logic [7:0] proc_prio
);
  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic [NVEC-1:0] irr_d, isr_d, tmr_d;
  vec_t            tpr_q;
  logic            irr_any, isr_any;
  vec_t            irr_top, isr_top, ppr;
  logic            ack, req_take;

  irq_msb_find #(.N(NVEC), .IW(VW)) u_irr_find (
    .bits(irr_q), .any(irr_any), .idx(irr_top));
  irq_msb_find #(.N(NVEC), .IW(VW)) u_isr_find (
    .bits(isr_q), .any(isr_any), .idx(isr_top));
  irq_prio_calc u_prio (
    .tpr_i(tpr_q), .isr_any(isr_any), .isr_top(isr_top), .ppr_o(ppr));

  assign req_ready    = 1'b1;
  assign req_take     = req_valid && (req_vector >= vec_t'(MINV));
  assign offer_vector = irr_top;
  assign offer_valid  = enable && irr_any && (class_of(irr_top) > ppr);
  assign ack          = offer_valid && offer_ready;

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack) begin
      irr_d[irr_top] = 1'b0;
      isr_d[irr_top] = 1'b1;
    end
    if (eoi && isr_any) isr_d[isr_top] = 1'b0;
    if (req_take) begin
      irr_d[req_vector] = 1'b1;
      tmr_d[req_vector] = req_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q           <= '0;
      isr_q           <= '0;
      tmr_q           <= '0;
      tpr_q           <= '0;
      eoi_done_valid  <= 1'b0;
      eoi_done_vector <= '0;
      eoi_done_level  <= 1'b0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
      if (tpr_wr)             tpr_q <= tpr_wdata;
      else if (prio_class_wr) tpr_q <= {prio_class_wdata, {SUBW{1'b0}}};
      eoi_done_valid <= eoi && isr_any;
      if (eoi && isr_any) begin
        eoi_done_vector <= isr_top;
        eoi_done_level  <= tmr_q[isr_top];
      end
    end
  end

  assign tpr              = tpr_q;
  assign proc_prio        = ppr;
  assign prio_class_rdata = tpr_q[VW-1:SUBW];

  // R4: acknowledged vector lands in service and leaves the pending map
  a_r4_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(req_take && req_vector == offer_vector))
    |=> (isr_q[$past(offer_vector)] && !irr_q[$past(offer_vector)]));

  // R10: low vectors never become pending
  a_r10_low_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vector < 8'd16 && !irr_q[req_vector])
    |=> !irr_q[$past(req_vector)]);

  // R6: EOI on an empty in-service map leaves it empty
  a_r6_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_q == '0 && !ack) |=> (isr_q == '0 && !eoi_done_valid));

  // R3: an offered vector's class beats the processor priority
  a_r3_offer_beats_ppr: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_vector[7:4] > proc_prio[7:4]));

  // R5: processor priority never falls below the task priority
  a_r5_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
    proc_prio >= tpr);

  // R12: a request colliding with its own acknowledge stays pending
  a_r12_collide_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_take && req_vector == offer_vector)
    |=> irr_q[$past(req_vector)]);
endmodule

// File: tb/irq_accept_core_test.sv
module irq_accept_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_vector = '0;
  logic       req_level = 1'b0;
  logic       offer_valid;
  logic       offer_ready = 1'b0;
  logic [7:0] offer_vector;
  logic       eoi = 1'b0;
  logic       eoi_done_valid;
  logic [7:0] eoi_done_vector;
  logic       eoi_done_level;
  logic       tpr_wr = 1'b0;
  logic [7:0] tpr_wdata = '0;
  logic       prio_class_wr = 1'b0;
  logic [3:0] prio_class_wdata = '0;
  logic [3:0] prio_class_rdata;
  logic [7:0] tpr;
  logic [7:0] proc_prio;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_accept_core uut (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic request(int v, bit lvl);
    @(negedge clk);
    req_valid = 1'b1; req_vector = 8'(v); req_level = lvl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    offer_ready = 1'b1;
    @(negedge clk);
    offer_ready = 1'b0;
  endtask

  task automatic retire();
    @(negedge clk);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic set_class(int c);
    @(negedge clk);
    prio_class_wr = 1'b1; prio_class_wdata = 4'(c);
    @(negedge clk);
    prio_class_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 offer_valid", offer_valid, 0);
    check("R1 proc_prio", proc_prio, 0);
    check("R1 tpr", tpr, 0);
    check("R1 class read", prio_class_rdata, 0);
    check("R12 req_ready", req_ready, 1);

    // R2 disabled controller offers nothing but collects requests
    request(8'h40, 0);
    check("R2 disabled offer", offer_valid, 0);
    @(negedge clk); enable = 1'b1;
    #1;
    check("R2 enabled offer", offer_valid, 1);
    check("R2 enabled vector", offer_vector, 8'h40);
    take(); retire();

    // R10 low vectors are discarded
    for (int v = 0; v < 16; v++) begin
      request(v, 0);
      check("R10 low vector dropped", offer_valid, 0);
    end

    // R4 R5 R6 sweep every acceptable vector alone
    for (int v = 16; v < 256; v++) begin
      request(v, v[0]);
      check("R3 single offer valid", offer_valid, 1);
      check("R3 single offer vector", offer_vector, v);
      take();
      check("R4 ppr after ack", proc_prio, v & 8'hF0);
      check("R4 nothing pending", offer_valid, 0);
      retire();
      check("R6 retire valid", eoi_done_valid, 1);
      check("R6 retire vector", eoi_done_vector, v);
      check("R11 retire level", eoi_done_level, v & 1);
      check("R6 ppr restored", proc_prio, 0);
    end

    // R7 R3 task priority class sweep against a class-8 vector
    for (int c = 0; c < 16; c++) begin
      set_class(c);
      check("R7 class read", prio_class_rdata, c);
      check("R7 tpr value", tpr, c << 4);
      request(8'h80, 0);
      check("R3 class gate", offer_valid, (8 > c) ? 1 : 0);
      set_class(0);
      take(); retire();
    end

    // R3 ordering and R5 nesting
    request(8'h35, 0); request(8'h92, 0); request(8'h61, 0);
    check("R3 highest offered", offer_vector, 8'h92);
    take();
    check("R5 ppr from isr", proc_prio, 8'h90);
    check("R3 lower class held", offer_valid, 0);
    retire();
    check("R6 retired 92", eoi_done_vector, 8'h92);
    check("R3 next offered", offer_vector, 8'h61);
    take();
    request(8'hA0, 1);
    check("R3 preempt offered", offer_vector, 8'hA0);
    check("R3 preempt valid", offer_valid, 1);
    take();
    check("R5 nested ppr", proc_prio, 8'hA0);
    retire();
    check("R6 highest retired first", eoi_done_vector, 8'hA0);
    check("R11 level flag", eoi_done_level, 1);
    check("R5 ppr back to 60", proc_prio, 8'h60);
    retire();
    take(); retire();
    check("R6 retired 35", eoi_done_vector, 8'h35);

    // R6 EOI with empty in-service map
    retire();
    check("R6 empty eoi", eoi_done_valid, 0);
    check("R6 empty ppr", proc_prio, 0);

    // R9 duplicate request merges
    request(8'h50, 0); request(8'h50, 0);
    take(); retire();
    check("R9 merged", offer_valid, 0);

    // R8 full write, and precedence over the alias
    @(negedge clk);
    tpr_wr = 1'b1; tpr_wdata = 8'h5A; prio_class_wr = 1'b1; prio_class_wdata = 4'h2;
    @(negedge clk);
    tpr_wr = 1'b0; prio_class_wr = 1'b0;
    check("R8 full wins", tpr, 8'h5A);
    check("R5 ppr equals tpr", proc_prio, 8'h5A);
    check("R7 alias of full", prio_class_rdata, 5);
    request(8'h5F, 0);
    check("R3 equal class held", offer_valid, 0);
    request(8'h60, 0);
    check("R3 higher class offered", offer_vector, 8'h60);
    set_class(0);
    take();
    check("R5 isr above tpr", proc_prio, 8'h60);
    retire();
    take(); retire();
    check("R6 retired 5F", eoi_done_vector, 8'h5F);

    // R12 request colliding with its acknowledge is kept
    request(8'h70, 0);
    @(negedge clk);
    offer_ready = 1'b1; req_valid = 1'b1; req_vector = 8'h70;
    @(negedge clk);
    offer_ready = 1'b0; req_valid = 1'b0;
    check("R12 held behind isr", offer_valid, 0);
    retire();
    check("R12 kept pending", offer_valid, 1);
    check("R12 kept vector", offer_vector, 8'h70);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule